// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns one load or store request into the memory beats that carry it out. From a 32-bit base value, a 13-bit signed immediate, an access size and an indexing mode, it computes the address of the access and the value that the base register takes afterwards. It then runs a simple request/ready exchange with the memory side. A doubleword takes two word beats; every other size takes one beat.

On stores the unit places the source data in the byte lanes selected by the low address bits and raises the matching byte enables. On loads it moves the addressed byte or halfword down to bit 0 and zero-extends it. A doubleword is assembled into a low word and a high word. When the operation ends, a one-cycle completion pulse carries the load results, the new base value and a flag that says whether the base is to be written back.

Top module: `ls_agu`

## Requirements
- R1: In mode 0 (plain offset), and in mode 3, which acts the same way, the access address is base + offset, and `wb_valid_o` is low on the completion pulse.
- R2: In mode 1 (pre-index) the access address is base + offset, `wb_value_o` is base + offset, and `wb_valid_o` is high on the completion pulse.
- R3: In mode 2 (post-index) the access address is the unmodified base, `wb_value_o` is base + offset, and `wb_valid_o` is high on the completion pulse.
- R4: `offset_i` is a 13-bit two's-complement value that is sign-extended to 32 bits before the addition (13'h1FF4 is -12; 13'h1000 is -4096).
- R5: Size 3 (doubleword) issues two beats, at address A and then A+4. A store sends `wdata_lo_i` on the first beat and `wdata_hi_i` on the second. A load returns the first beat's word on `ld_lo_o` and the second beat's word on `ld_hi_o`. There is one completion pulse, after the second beat.
- R6: Size 0 (byte) store: `req_be_o` is 1 shifted left by A[1:0], and `req_wdata_o` is `wdata_lo_i[7:0]` shifted left by 8*A[1:0], with all other bits zero.
- R7: Size 1 (halfword) store: `req_be_o` is 4'b0011 when A[1]=0 and 4'b1100 when A[1]=1, and `req_wdata_o` is `wdata_lo_i[15:0]` shifted left by 16*A[1].
- R8: Size 2 (word) store: `req_be_o` is 4'b1111 and `req_wdata_o` equals `wdata_lo_i`.
- R9: Byte and halfword loads return the addressed lane of `rdata_i` on `ld_lo_o`, shifted down to bit 0 and zero-extended. `ld_hi_o` is zero for every size except doubleword.
- R10: A beat completes on a cycle in which both `req_o` and `req_ready_i` are high. While `req_ready_i` is low, `req_o`, the address, the enables and the write data hold steady.
- R11: `done_o` is high for exactly one cycle, in the cycle after the last beat completes. `start_i` is accepted only while `busy_o` is low, and a pulse on it during an operation causes no extra beat.
- R12: After reset, `req_o`, `done_o`, `busy_o` and `wb_valid_o` are low.

`is_store_i` is 1 for a store and 0 for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| mode_i | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 as offset |
| base_i | input | 32 | Base register value |
| offset_i | input | 13 | Signed immediate offset |
| wdata_lo_i | input | 32 | Store source (low word) |
| wdata_hi_i | input | 32 | Store source high word (doubleword only) |
| busy_o | output | 1 | Operation in progress |
| req_o | output | 1 | Memory beat request |
| req_we_o | output | 1 | Beat is a write |
| req_addr_o | output | 32 | Beat address |
| req_be_o | output | 4 | Byte-lane enables |
| req_wdata_o | output | 32 | Lane-positioned write data |
| req_ready_i | input | 1 | Memory accepts the beat; read data valid |
| rdata_i | input | 32 | Read data for the current beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Base writeback required (with done_o) |
| wb_value_o | output | 32 | New base value |
| ld_lo_o | output | 32 | Load result, low word |
| ld_hi_o | output | 32 | Load result, high word |

## Verification
Embedded properties check on every cycle that a stalled beat holds its request, address and data steady, that completion lasts one cycle and never overlaps a request, that the writeback flag appears only with completion, that a doubleword's second beat sits four bytes above its first, and that a byte store enables exactly one lane. The bench scenarios are needed for the arithmetic results: the address and writeback values in each indexing mode, including negative and extreme offsets, the lane placement and zero-extension for each address alignment, and the assembly of a doubleword. They also show that a start pulse arriving mid-operation has no effect.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DBL = 2'd3} acc_size_e;
  typedef enum logic [1:0] {IX_OFF = 2'd0, IX_PRE = 2'd1, IX_POST = 2'd2, IX_RSV = 2'd3} idx_mode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BEAT0 = 2'd1, ST_BEAT1 = 2'd2, ST_DONE = 2'd3} seq_state_e;
endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 13
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  idx_mode_e     mode_i,
  output logic [AW-1:0] access_addr_o,
  output logic [AW-1:0] wb_value_o
);
  localparam int unsigned EXT = AW - OW;

  logic [AW-1:0] off_ext;
  logic [AW-1:0] sum;

  always_comb begin
    off_ext       = {{EXT{offset_i[OW-1]}}, offset_i};
    sum           = base_i + off_ext;
    wb_value_o    = sum;
    access_addr_o = (mode_i == IX_POST) ? base_i : sum;
  end
endmodule

// File: rtl/agu_lane.sv
module agu_lane
  import agu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  acc_size_e     size_i,
  input  logic [$clog2(DW/8)-1:0] addr_lo_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] ld_word_o
);
  localparam int unsigned NB = DW / 8;
  localparam int unsigned LB = $clog2(NB);

  logic [LB-1:0] half_a;
  logic [LB+2:0] sh_b;
  logic [LB+2:0] sh_h;
  logic [DW-1:0] src_b;
  logic [DW-1:0] src_h;

  always_comb begin
    half_a = {addr_lo_i[LB-1:1], 1'b0};
    sh_b   = {addr_lo_i, 3'b000};
    sh_h   = {half_a, 3'b000};
    src_b  = {{(DW-8){1'b0}}, src_i[7:0]};
    src_h  = {{(DW-16){1'b0}}, src_i[15:0]};
    case (size_i)
      SZ_BYTE: begin
        be_o      = NB'(1) << addr_lo_i;
        wdata_o   = src_b << sh_b;
        ld_word_o = (rdata_i >> sh_b) & DW'(8'hFF);
      end
      SZ_HALF: begin
        be_o      = NB'(3) << half_a;
        wdata_o   = src_h << sh_h;
        ld_word_o = (rdata_i >> sh_h) & DW'(16'hFFFF);
      end
      default: begin
        be_o      = '1;
        wdata_o   = src_i;
        ld_word_o = rdata_i;
      end
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_store_i,
  input  acc_size_e     size_i,
  input  idx_mode_e     mode_i,
  input  logic [AW-1:0] access_addr_i,
  input  logic [AW-1:0] wb_sum_i,
  input  logic [DW-1:0] wlo_i,
  input  logic [DW-1:0] whi_i,
  input  logic          ready_i,
  input  logic [DW-1:0] ld_word_i,
  output logic          busy_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] cur_addr_o,
  output acc_size_e     size_o,
  output logic [DW-1:0] src_o,
  output logic          done_o,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_value_o,
  output logic [DW-1:0] ld_lo_o,
  output logic [DW-1:0] ld_hi_o
);
  localparam int unsigned NB = DW / 8;

  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, wb_q;
  logic [DW-1:0] wlo_q, whi_q, ld_lo_q, ld_hi_q;
  acc_size_e     size_q;
  idx_mode_e     mode_q;
  logic          store_q;
  logic          cap_en, lo_en, hi_en, fire;

  always_comb begin
    fire    = req_o && ready_i;
    cap_en  = (state_q == ST_IDLE) && start_i;
    lo_en   = (state_q == ST_BEAT0) && fire && !store_q;
    hi_en   = (state_q == ST_BEAT1) && fire && !store_q;
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_BEAT0;
      ST_BEAT0: if (ready_i) state_d = (size_q == SZ_DBL) ? ST_BEAT1 : ST_DONE;
      ST_BEAT1: if (ready_i) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wb_q    <= '0;
      wlo_q   <= '0;
      whi_q   <= '0;
      size_q  <= SZ_BYTE;
      mode_q  <= IX_OFF;
      store_q <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= access_addr_i;
      wb_q    <= wb_sum_i;
      wlo_q   <= wlo_i;
      whi_q   <= whi_i;
      size_q  <= size_i;
      mode_q  <= mode_i;
      store_q <= is_store_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_lo_q <= '0;
      ld_hi_q <= '0;
    end else begin
      if (cap_en)     ld_lo_q <= '0;
      else if (lo_en) ld_lo_q <= ld_word_i;
      if (cap_en)     ld_hi_q <= '0;
      else if (hi_en) ld_hi_q <= ld_word_i;
    end
  end

  always_comb begin
    busy_o     = (state_q != ST_IDLE);
    req_o      = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
    done_o     = (state_q == ST_DONE);
    we_o       = store_q;
    cur_addr_o = addr_q + ((state_q == ST_BEAT1) ? AW'(NB) : '0);
    size_o     = size_q;
    src_o      = (state_q == ST_BEAT1) ? whi_q : wlo_q;
    wb_valid_o = done_o && ((mode_q == IX_PRE) || (mode_q == IX_POST));
    wb_value_o = wb_q;
    ld_lo_o    = ld_lo_q;
    ld_hi_o    = ld_hi_q;
  end

  AST_DBL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BEAT1 && $past(state_q) == ST_BEAT0) |-> cur_addr_o == $past(cur_addr_o) + AW'(NB)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o); // R1
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_o); // R11
endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 13,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_store_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  logic [DW-1:0] wdata_lo_i,
  input  logic [DW-1:0] wdata_hi_i,
  output logic          busy_o,
  output logic          req_o,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW/8-1:0] req_be_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          req_ready_i,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_value_o,
  output logic [DW-1:0] ld_lo_o,
  output logic [DW-1:0] ld_hi_o
);
  localparam int unsigned LB = $clog2(DW / 8);

  logic [1:0]    rst_sync;
  logic          rst_q_n;
  logic [AW-1:0] acc_addr, wb_sum;
  acc_size_e     size_q;
  logic [DW-1:0] src_data, ld_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  agu_addr_calc #(.AW(AW), .OW(OW)) u_calc (
    .base_i        (base_i),
    .offset_i      (offset_i),
    .mode_i        (idx_mode_e'(mode_i)),
    .access_addr_o (acc_addr),
    .wb_value_o    (wb_sum)
  );

  agu_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .start_i       (start_i),
    .is_store_i    (is_store_i),
    .size_i        (acc_size_e'(size_i)),
    .mode_i        (idx_mode_e'(mode_i)),
    .access_addr_i (acc_addr),
    .wb_sum_i      (wb_sum),
    .wlo_i         (wdata_lo_i),
    .whi_i         (wdata_hi_i),
    .ready_i       (req_ready_i),
    .ld_word_i     (ld_word),
    .busy_o        (busy_o),
    .req_o         (req_o),
    .we_o          (req_we_o),
    .cur_addr_o    (req_addr_o),
    .size_o        (size_q),
    .src_o         (src_data),
    .done_o        (done_o),
    .wb_valid_o    (wb_valid_o),
    .wb_value_o    (wb_value_o),
    .ld_lo_o       (ld_lo_o),
    .ld_hi_o       (ld_hi_o)
  );

  agu_lane #(.DW(DW)) u_lane (
    .size_i    (size_q),
    .addr_lo_i (req_addr_o[LB-1:0]),
    .src_i     (src_data),
    .rdata_i   (rdata_i),
    .be_o      (req_be_o),
    .wdata_o   (req_wdata_o),
    .ld_word_o (ld_word)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_o && !req_ready_i) |=> (req_o && $stable(req_addr_o) && $stable(req_be_o) && $stable(req_wdata_o))); // R10
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_o && req_we_o && size_q == SZ_BYTE) |-> $countones(req_be_o) == 1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy_o |-> (!req_o && !done_o)); // R12
endmodule

// File: tb/tb_ls_agu.sv
module tb_ls_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, is_store_i, req_ready_i;
  logic [1:0]  size_i, mode_i;
  logic [31:0] base_i, wdata_lo_i, wdata_hi_i, rdata_i;
  logic [12:0] offset_i;
  logic        busy_o, req_o, req_we_o, done_o, wb_valid_o;
  logic [31:0] req_addr_o, req_wdata_o, wb_value_o, ld_lo_o, ld_hi_o;
  logic [3:0]  req_be_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] obs_addr [2];
  logic [31:0] obs_wd [2];
  logic [3:0]  obs_be [2];
  logic [31:0] obs_lo, obs_hi, obs_wb;
  logic        obs_wbv, stall_bad, after_quiet;
  int          obs_beats;

  always #4 clk = ~clk;

  ls_agu dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_store_i(is_store_i),
    .size_i(size_i), .mode_i(mode_i), .base_i(base_i), .offset_i(offset_i),
    .wdata_lo_i(wdata_lo_i), .wdata_hi_i(wdata_hi_i), .busy_o(busy_o),
    .req_o(req_o), .req_we_o(req_we_o), .req_addr_o(req_addr_o), .req_be_o(req_be_o),
    .req_wdata_o(req_wdata_o), .req_ready_i(req_ready_i), .rdata_i(rdata_i),
    .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_value_o(wb_value_o),
    .ld_lo_o(ld_lo_o), .ld_hi_o(ld_hi_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit st, input logic [1:0] sz, input logic [1:0] md,
                        input logic [31:0] base, input logic [12:0] off,
                        input logic [31:0] wlo, input logic [31:0] whi,
                        input logic [31:0] rlo, input logic [31:0] rhi,
                        input int stall, input bit poke);
    int left = stall;
    logic [31:0] held;
    @(negedge clk);
    is_store_i = st; size_i = sz; mode_i = md; base_i = base; offset_i = off;
    wdata_lo_i = wlo; wdata_hi_i = whi; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    obs_beats = 0; stall_bad = 1'b0; held = req_addr_o;
    for (int g = 0; g < 40 && !done_o; g++) begin
      start_i = 1'b0;
      req_ready_i = 1'b0;
      if (req_o) begin
        if (left > 0) begin
          if (left != stall && req_addr_o != held) stall_bad = 1'b1;
          held = req_addr_o;
          left--;
          if (poke) begin
            start_i = 1'b1; base_i = 32'hDEAD0000;
          end
        end else if (obs_beats < 2) begin
          obs_addr[obs_beats] = req_addr_o;
          obs_be[obs_beats]   = req_be_o;
          obs_wd[obs_beats]   = req_wdata_o;
          rdata_i = (obs_beats == 0) ? rlo : rhi;
          req_ready_i = 1'b1;
          obs_beats++;
        end
      end
      @(negedge clk);
    end
    start_i = 1'b0; req_ready_i = 1'b0;
    obs_lo = ld_lo_o; obs_hi = ld_hi_o; obs_wb = wb_value_o; obs_wbv = wb_valid_o;
    chk(done_o, "R11 done seen", 32'(done_o), 32'd1);
    @(negedge clk);
    after_quiet = !done_o && !req_o && !busy_o;
  endtask

  task automatic t_reset;
    chk(!req_o && !done_o && !busy_o && !wb_valid_o, "R12 reset state",
        {28'd0, req_o, done_o, busy_o, wb_valid_o}, 32'd0);
  endtask

  task automatic t_offset_load;
    access(1'b0, 2'd2, 2'd0, 32'h0000_1000, 13'h0020, 0, 0, 32'hCAFE_BABE, 0, 0, 1'b0);
    chk(obs_addr[0] == 32'h1020, "R1 offset address", obs_addr[0], 32'h1020);
    chk(!obs_wbv, "R1 no writeback", 32'(obs_wbv), 0);
    chk(obs_lo == 32'hCAFE_BABE, "R9 word load", obs_lo, 32'hCAFE_BABE);
    chk(obs_beats == 1, "R5 single beat", obs_beats, 1);
    access(1'b0, 2'd2, 2'd3, 32'h0000_1000, 13'h0010, 0, 0, 32'h1, 0, 0, 1'b0);
    chk(obs_addr[0] == 32'h1010 && !obs_wbv, "R1 mode 3 as offset", obs_addr[0], 32'h1010);
  endtask

  task automatic t_pre_store;
    access(1'b1, 2'd2, 2'd1, 32'h0000_2000, 13'd20, 32'h1234_5678, 0, 0, 0, 0, 1'b0);
    chk(obs_addr[0] == 32'h2014, "R2 pre address", obs_addr[0], 32'h2014);
    chk(obs_wbv && obs_wb == 32'h2014, "R2 pre writeback", obs_wb, 32'h2014);
    chk(obs_be[0] == 4'hF, "R8 word enables", 32'(obs_be[0]), 32'hF);
    chk(obs_wd[0] == 32'h1234_5678, "R8 word data", obs_wd[0], 32'h1234_5678);
  endtask

  task automatic t_post_neg;
    access(1'b1, 2'd2, 2'd2, 32'h0000_3000, 13'h1FF4, 32'h55, 0, 0, 0, 0, 1'b0);
    chk(obs_addr[0] == 32'h3000, "R3 post address", obs_addr[0], 32'h3000);
    chk(obs_wbv && obs_wb == 32'h2FF4, "R3 R4 post writeback -12", obs_wb, 32'h2FF4);
    access(1'b0, 2'd2, 2'd0, 32'h0001_0000, 13'h1000, 0, 0, 0, 0, 0, 1'b0);
    chk(obs_addr[0] == 32'h0000_F000, "R4 offset -4096", obs_addr[0], 32'hF000);
    access(1'b0, 2'd2, 2'd1, 32'h0001_0000, 13'h0FFF, 0, 0, 0, 0, 0, 1'b0);
    chk(obs_wb == 32'h0001_0FFF, "R4 offset +4095", obs_wb, 32'h1_0FFF);
  endtask

  task automatic t_byte_store;
    for (int a = 0; a < 4; a++) begin
      access(1'b1, 2'd0, 2'd0, 32'h100 + 32'(a), 13'd0, 32'h1122_3344, 0, 0, 0, 0, 1'b0);
      chk(obs_be[0] == (4'd1 << a), "R6 byte enables", 32'(obs_be[0]), 32'(4'd1 << a));
      chk(obs_wd[0] == (32'h44 << (8 * a)), "R6 byte data", obs_wd[0], 32'h44 << (8 * a));
    end
  endtask

  task automatic t_half_store;
    access(1'b1, 2'd1, 2'd0, 32'h200, 13'd0, 32'hAABB_CCDD, 0, 0, 0, 0, 1'b0);
    chk(obs_be[0] == 4'b0011 && obs_wd[0] == 32'h0000_CCDD, "R7 low half", obs_wd[0], 32'hCCDD);
    access(1'b1, 2'd1, 2'd0, 32'h200, 13'd2, 32'hAABB_CCDD, 0, 0, 0, 0, 1'b0);
    chk(obs_be[0] == 4'b1100 && obs_wd[0] == 32'hCCDD_0000, "R7 high half", obs_wd[0], 32'hCCDD_0000);
  endtask

  task automatic t_narrow_load;
    access(1'b0, 2'd0, 2'd0, 32'h301, 13'd0, 0, 0, 32'hA1B2_C3D4, 0, 0, 1'b0);
    chk(obs_lo == 32'h0000_00C3, "R9 byte load lane 1", obs_lo, 32'hC3);
    chk(obs_hi == 32'h0, "R9 high word zero", obs_hi, 0);
    access(1'b0, 2'd1, 2'd0, 32'h302, 13'd0, 0, 0, 32'hA1B2_C3D4, 0, 0, 1'b0);
    chk(obs_lo == 32'h0000_A1B2, "R9 half load upper", obs_lo, 32'hA1B2);
    access(1'b0, 2'd0, 2'd0, 32'h303, 13'd0, 0, 0, 32'hF1B2_C3D4, 0, 0, 1'b0);
    chk(obs_lo == 32'h0000_00F1, "R9 byte load zero-extend", obs_lo, 32'hF1);
  endtask

  task automatic t_dbl;
    access(1'b0, 2'd3, 2'd1, 32'h4000, 13'd8, 0, 0, 32'h1111_1111, 32'h2222_2222, 0, 1'b0);
    chk(obs_beats == 2, "R5 two beats", obs_beats, 2);
    chk(obs_addr[0] == 32'h4008 && obs_addr[1] == 32'h400C, "R5 beat addresses", obs_addr[1], 32'h400C);
    chk(obs_lo == 32'h1111_1111 && obs_hi == 32'h2222_2222, "R5 load halves", obs_hi, 32'h2222_2222);
    chk(obs_wbv && obs_wb == 32'h4008, "R5 R2 dword writeback", obs_wb, 32'h4008);
    chk(after_quiet, "R11 one done pulse", 32'(after_quiet), 1);
    access(1'b1, 2'd3, 2'd2, 32'h5000, 13'h1FF8, 32'hAAAA_0001, 32'hBBBB_0002, 0, 0, 0, 1'b0);
    chk(obs_addr[0] == 32'h5000 && obs_addr[1] == 32'h5004, "R5 R3 post dword addresses", obs_addr[1], 32'h5004);
    chk(obs_wd[0] == 32'hAAAA_0001 && obs_wd[1] == 32'hBBBB_0002, "R5 store halves", obs_wd[1], 32'hBBBB_0002);
    chk(obs_wb == 32'h4FF8, "R3 dword writeback", obs_wb, 32'h4FF8);
  endtask

  task automatic t_stall;
    access(1'b1, 2'd2, 2'd0, 32'h6000, 13'd4, 32'h77, 0, 0, 0, 3, 1'b1);
    chk(!stall_bad, "R10 address held while stalled", 32'(stall_bad), 0);
    chk(obs_addr[0] == 32'h6004, "R10 R11 start ignored while busy", obs_addr[0], 32'h6004);
    chk(obs_beats == 1, "R10 one beat after stall", obs_beats, 1);
    chk(after_quiet, "R11 no extra beat after done", 32'(after_quiet), 1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 0; is_store_i = 0; size_i = 0; mode_i = 0;
    base_i = 0; offset_i = 0; wdata_lo_i = 0; wdata_hi_i = 0;
    req_ready_i = 0; rdata_i = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_offset_load();
    t_pre_store();
    t_post_neg();
    t_byte_store();
    t_half_store();
    t_narrow_load();
    t_dbl();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule